// File: doc/BRIEF.md
# Dual-Lane Serial Result Shifter

This block is the serial read-out stage of an eight-channel sampling front end. It holds a bank of conversion results. While the host keeps chip-select low, it shifts those results out on two serial data lanes, paced by a host-supplied serial clock. Lane A starts at the first channel. Lane B starts at the channel halfway through the bank. Both lanes walk upward through the channels, so with both lanes in use the host gets the whole bank in half the clock pulses. A host that wires up only one lane keeps clocking and receives every channel in order from that lane.

The serial clock and chip-select are sampled in the block's own clock domain. A new bit is presented after each falling edge of the serial clock, so the host can capture it on the next rising edge. The result bank is refreshed when the conversion-busy input falls. While busy is high, a read returns the previous conversion. If busy falls during a frame, the refresh is held back until chip-select rises, so a frame never mixes two conversions.

Top module: `dual_lane_shifter`

## Requirements
- R1: After reset the lane enable is 0, both lanes drive 0, and every stored result is 0 until the first load.
- R2: One clock after chip-select is sampled high, the lane enable is 0 and both lanes drive 0 (the outputs are treated as high impedance).
- R3: One clock after chip-select is sampled low, the lane enable is 1. Lane A presents bit 15 of channel 0 and lane B presents bit 15 of channel NCH/2.
- R4: Each serial clock falling edge seen during a frame advances both lanes by one bit. Words are sent MSB first, 16 bits per channel. The lanes hold still between falling edges.
- R5: After the 16th bit of a word, the next falling edge moves each lane to its next channel.
- R6: Lane A continues from channel NCH/2-1 into channel NCH/2 and wraps from channel NCH-1 to channel 0. Lane B wraps from channel NCH-1 to channel 0, so either lane alone yields all channels in ascending order.
- R7: Raising chip-select clears the bit and channel position. The next frame starts again at R3's position, even if the previous frame stopped in the middle of a word.
- R8: A falling edge of busy with chip-select high loads the bank from conv_data. Channel i is taken from conv_data[i*16 +: 16].
- R9: While busy stays high, changes on conv_data and busy rising have no effect: frames return the previously loaded results.
- R10: If busy falls while a frame is open, the rest of that frame returns the old results. The new results are loaded once chip-select has risen, and the next frame returns them.
- R11: Serial clock edges while chip-select is high do not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial clock and chip-select are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip-select framing a read |
| sclk | input | 1 | Host serial clock; falling edges advance the lanes |
| busy | input | 1 | Conversion in progress; its falling edge marks new results |
| conv_data | input | NCH*RES_W | Fresh conversion results, channel i in slice i |
| dout_a | output | 1 | Lane A serial data |
| dout_b | output | 1 | Lane B serial data |
| dout_en | output | 1 | Lane drive enable; 0 means the lanes are released |

## Verification
The checks assume that the serial clock and chip-select are already synchronous to clk, and that each level of the serial clock lasts at least one clk period. They also assume conv_data holds its value from the fall of busy until any deferred load has taken place. The stimulus drives every input on the falling edge of clk and holds each serial clock level for one or more whole clk cycles, with random idle gaps. It changes conv_data only while busy is high, and keeps it unchanged until the next load. Chip-select is kept high across reset release.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef struct packed {
    logic sclk_fall;
    logic busy_fall;
  } dls_evt_t;

  function automatic int unsigned lane_base(input int unsigned lane, input int unsigned nch);
    return lane * (nch / 2);
  endfunction

endpackage

// File: rtl/dls_edge.sv
module dls_edge
  import dls_pkg::*;
(
  input  logic     clk,
  input  logic     rst_q,
  input  logic     cs_n,
  input  logic     sclk,
  input  logic     busy,
  output dls_evt_t evt,
  output logic     frame_act
);

  logic sclk_q, busy_q, act_q;
  logic act_d;

  always_comb begin
    act_d         = ~cs_n;
    evt.sclk_fall = sclk_q & ~sclk & ~cs_n & act_q;
    evt.busy_fall = busy_q & ~busy;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      busy_q <= busy;
      act_q  <= act_d;
    end
  end

  assign frame_act = act_q;

endmodule

// File: rtl/dls_seq.sv
module dls_seq #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 16,
  localparam int unsigned BW   = $clog2(RES_W),
  localparam int unsigned CW   = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          cs_n,
  input  logic          sclk_fall,
  output logic [BW-1:0] bit_idx,
  output logic [CW-1:0] ch_ptr
);

  localparam logic [BW-1:0] BIT_LAST = BW'(RES_W - 1);
  localparam logic [CW-1:0] CH_LAST  = CW'(NCH - 1);

  logic [BW-1:0] bit_d;
  logic [CW-1:0] ch_d;
  logic          upd;

  always_comb begin
    upd   = cs_n | sclk_fall;
    bit_d = bit_idx;
    ch_d  = ch_ptr;
    if (cs_n) begin
      bit_d = '0;
      ch_d  = '0;
    end else if (sclk_fall) begin
      if (bit_idx == BIT_LAST) begin
        bit_d = '0;
        ch_d  = (ch_ptr == CH_LAST) ? '0 : ch_ptr + 1'b1;
      end else begin
        bit_d = bit_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bit_idx <= '0;
      ch_ptr  <= '0;
    end else if (upd) begin
      bit_idx <= bit_d;
      ch_ptr  <= ch_d;
    end
  end

endmodule

// File: rtl/dls_bank.sv
module dls_bank #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 16,
  localparam int unsigned TOT  = NCH * RES_W
) (
  input  logic           clk,
  input  logic           rst_q,
  input  logic           busy_fall,
  input  logic           frame_act,
  input  logic [TOT-1:0] conv_data,
  output logic [TOT-1:0] bank_q,
  output logic           bank_we
);

  logic pend_q, pend_d;

  always_comb begin
    bank_we = (busy_fall | pend_q) & ~frame_act;
    pend_d  = (busy_fall | pend_q) & frame_act;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bank_q <= '0;
    end else if (bank_we) begin
      bank_q <= conv_data;
    end
  end

endmodule

// File: rtl/dls_lane.sv
module dls_lane #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 16,
  parameter int unsigned OFS   = 0,
  localparam int unsigned BW   = $clog2(RES_W),
  localparam int unsigned CW   = $clog2(NCH),
  localparam int unsigned TOT  = NCH * RES_W
) (
  input  logic [TOT-1:0] bank_q,
  input  logic [BW-1:0]  bit_idx,
  input  logic [CW-1:0]  ch_ptr,
  input  logic           en,
  output logic           bit_o
);

  logic [CW:0]      sum;
  logic [CW-1:0]    chan;
  logic [RES_W-1:0] word;
  logic [BW-1:0]    pos;

  always_comb begin
    sum = {1'b0, ch_ptr} + (CW+1)'(OFS);
    if (sum >= (CW+1)'(NCH)) begin
      sum = sum - (CW+1)'(NCH);
    end
    chan  = sum[CW-1:0];
    word  = bank_q[chan*RES_W +: RES_W];
    pos   = BW'(RES_W - 1) - bit_idx;
    bit_o = en & word[pos];
  end

endmodule

// File: rtl/dual_lane_shifter.sv
module dual_lane_shifter
  import dls_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 16,
  localparam int unsigned BW   = $clog2(RES_W),
  localparam int unsigned CW   = $clog2(NCH),
  localparam int unsigned TOT  = NCH * RES_W,
  localparam int unsigned NLANE = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           busy,
  input  logic [TOT-1:0] conv_data,
  output logic           dout_a,
  output logic           dout_b,
  output logic           dout_en
);

  logic             rst_s0, rst_q;
  dls_evt_t         evt;
  logic             frame_act;
  logic [BW-1:0]    bit_idx;
  logic [CW-1:0]    ch_ptr;
  logic [TOT-1:0]   bank_q;
  logic             bank_we;
  logic [NLANE-1:0] lane_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_q  <= rst_s0;
    end
  end

  dls_edge u_edge (
    .clk       (clk),
    .rst_q     (rst_q),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .busy      (busy),
    .evt       (evt),
    .frame_act (frame_act)
  );

  dls_seq #(.NCH(NCH), .RES_W(RES_W)) u_seq (
    .clk       (clk),
    .rst_q     (rst_q),
    .cs_n      (cs_n),
    .sclk_fall (evt.sclk_fall),
    .bit_idx   (bit_idx),
    .ch_ptr    (ch_ptr)
  );

  dls_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
    .clk       (clk),
    .rst_q     (rst_q),
    .busy_fall (evt.busy_fall),
    .frame_act (frame_act),
    .conv_data (conv_data),
    .bank_q    (bank_q),
    .bank_we   (bank_we)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    dls_lane #(
      .NCH   (NCH),
      .RES_W (RES_W),
      .OFS   (lane_base(g, NCH))
    ) u_lane (
      .bank_q  (bank_q),
      .bit_idx (bit_idx),
      .ch_ptr  (ch_ptr),
      .en      (frame_act),
      .bit_o   (lane_bit[g])
    );
  end

  assign dout_a  = lane_bit[0];
  assign dout_b  = lane_bit[1];
  assign dout_en = frame_act;

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 16,
  localparam int unsigned BW   = $clog2(RES_W),
  localparam int unsigned CW   = $clog2(NCH)
) (
  input logic          clk,
  input logic          rst_q,
  input logic          cs_n,
  input logic          dout_a,
  input logic          dout_b,
  input logic          dout_en,
  input logic          sclk_fall,
  input logic          bank_we,
  input logic [BW-1:0] bit_idx,
  input logic [CW-1:0] ch_ptr
);

  assert_idle_hiz_R2: assert property (@(posedge clk) disable iff (!rst_q)
    cs_n |=> (!dout_en && !dout_a && !dout_b));

  assert_open_start_R3: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(cs_n) |=> (dout_en && bit_idx == '0 && ch_ptr == '0));

  assert_hold_between_edges_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (dout_en && $past(dout_en) && !$past(sclk_fall)) |-> ($stable(dout_a) && $stable(dout_b)));

  assert_word_advance_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (sclk_fall && bit_idx == BW'(RES_W - 1)) |=>
      (bit_idx == '0 && ch_ptr == (($past(ch_ptr) == CW'(NCH - 1)) ? '0 : $past(ch_ptr) + 1'b1)));

  assert_close_clear_R7: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(cs_n) |=> (bit_idx == '0 && ch_ptr == '0 && !dout_en));

  assert_load_outside_frame_R10: assert property (@(posedge clk) disable iff (!rst_q)
    bank_we |-> !dout_en);

  assert_idle_frozen_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (cs_n && $past(cs_n)) |-> (bit_idx == '0 && ch_ptr == '0));

endmodule

bind dual_lane_shifter dls_checker #(.NCH(NCH), .RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .cs_n      (cs_n),
  .dout_a    (dout_a),
  .dout_b    (dout_b),
  .dout_en   (dout_en),
  .sclk_fall (evt.sclk_fall),
  .bank_we   (bank_we),
  .bit_idx   (bit_idx),
  .ch_ptr    (ch_ptr)
);

// File: tb/sim_dual_lane_shifter.sv
`timescale 1ns/1ps
module sim_dual_lane_shifter;

  localparam int NCH  = 8;
  localparam int RW   = 16;
  localparam int HALF = NCH / 2;
  typedef logic [NCH-1:0][RW-1:0] bank_t;

  logic clk, rst_n, cs_n, sclk, busy;
  logic [NCH*RW-1:0] conv_data;
  logic dout_a, dout_b, dout_en;

  bank_t model, staged;
  bit    pend, in_frame;
  int    checks, fails;

  dual_lane_shifter #(.NCH(NCH), .RES_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .busy(busy),
    .conv_data(conv_data), .dout_a(dout_a), .dout_b(dout_b), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] exp_word(input bank_t b, input int lane, input int w);
    return b[(w + lane * HALF) % NCH];
  endfunction

  function automatic bank_t rand_bank();
    bank_t b;
    for (int i = 0; i < NCH; i++) b[i] = RW'($urandom);
    return b;
  endfunction

  task automatic frame_open();
    cs_n = 1'b0;
    in_frame = 1'b1;
    tick();
    chk("R3", "enable at frame open", 32'(dout_en), 32'd1);
  endtask

  task automatic frame_close();
    cs_n = 1'b1;
    tick();
    chk("R2", "enable after close", 32'(dout_en), 32'd0);
    chk("R2", "lanes after close", {30'd0, dout_a, dout_b}, 32'd0);
    in_frame = 1'b0;
    if (pend) begin
      model = staged;
      pend  = 1'b0;
    end
    tick();
  endtask

  task automatic read_bits(input int n, output logic [RW-1:0] wa, output logic [RW-1:0] wb);
    wa = '0;
    wb = '0;
    for (int b = 0; b < n; b++) begin
      tick();
      wa = {wa[RW-2:0], dout_a};
      wb = {wb[RW-2:0], dout_b};
      sclk = 1'b1;
      tick();
      sclk = 1'b0;
      repeat ($urandom_range(0, 2)) tick();
    end
  endtask

  task automatic read_words(input int n, input int w0, input string req);
    logic [RW-1:0] wa, wb;
    for (int w = 0; w < n; w++) begin
      read_bits(RW, wa, wb);
      chk(req, $sformatf("lane A word %0d", w0 + w), 32'(wa), 32'(exp_word(model, 0, w0 + w)));
      chk(req, $sformatf("lane B word %0d", w0 + w), 32'(wb), 32'(exp_word(model, 1, w0 + w)));
    end
  endtask

  task automatic load_bank(input bank_t nb, input bit read_busy);
    busy = 1'b1;
    tick();
    conv_data = nb;
    repeat (3) tick();
    if (read_busy) begin
      frame_open();
      read_words(NCH, 0, "R9");
      frame_close();
    end
    busy = 1'b0;
    if (in_frame) begin
      staged = nb;
      pend   = 1'b1;
    end else begin
      model = nb;
    end
    repeat (2) tick();
  endtask

  initial begin
    logic [RW-1:0] ja, jb;
    bank_t nb;
    void'($urandom(32'd20240611));
    checks = 0; fails = 0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; busy = 1'b0; conv_data = '0;
    model = '0; staged = '0; pend = 1'b0; in_frame = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    chk("R1", "enable after reset", 32'(dout_en), 32'd0);
    chk("R1", "lanes after reset", {30'd0, dout_a, dout_b}, 32'd0);
    frame_open();
    read_words(HALF, 0, "R1");
    frame_close();

    for (int i = 0; i < NCH; i++) nb[i] = RW'(16'hA500 + 16'(i * 16'h0111));
    load_bank(nb, 1'b0);
    frame_open();
    read_words(HALF, 0, "R8");
    frame_close();

    frame_open();
    read_words(NCH + 2, 0, "R6");
    frame_close();

    load_bank(rand_bank(), 1'b1);
    frame_open();
    read_words(NCH, 0, "R5");
    frame_close();

    frame_open();
    read_words(1, 0, "R4");
    read_bits(5, ja, jb);
    frame_close();
    frame_open();
    read_words(2, 0, "R7");
    frame_close();

    cs_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      sclk = ~sclk;
      tick();
      chk("R11", "enable while deselected", 32'(dout_en), 32'd0);
    end
    sclk = 1'b0;
    tick();
    frame_open();
    read_words(1, 0, "R11");
    frame_close();

    frame_open();
    read_words(2, 0, "R10");
    load_bank(rand_bank(), 1'b0);
    read_words(2, 2, "R10");
    frame_close();
    frame_open();
    read_words(NCH, 0, "R10");
    frame_close();

    for (int it = 0; it < 6; it++) begin
      load_bank(rand_bank(), it[0]);
      frame_open();
      read_words($urandom_range(1, NCH + 3), 0, "R4");
      read_bits($urandom_range(0, RW - 1), ja, jb);
      frame_close();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule